// File: doc/BRIEF.md
# HDLC Frame Register Interface

This block is the processor-facing front end of an HDLC framer. Software moves whole frames through a handful of 32-bit registers. A transmit word is split into bytes and sent, lowest byte first, to the framer's byte stream. Receive bytes from the framer are gathered into 32-bit words that software reads. Bit stuffing, flag insertion and CRC generation stay inside the framer. This block deals only with words, bytes, frame boundaries and bus timing.

Software marks the last word of a frame by setting the end-of-frame bit and a 2-bit count of the valid bytes in that word. It can throw away a frame at any time with the discard command. Each transmit word can go through one of two registers. The plain data register never stalls: writing it while the byte path is still busy kills the frame. The stalling data register holds the bus with wait-request until the byte path is free. The receive data register also stalls until a full word is ready. Every stall is limited by a cycle counter, and an access that runs out of time completes with an error response. A sticky flag that clears when read records CRC errors reported by the framer.

Top module: `hdlc_frame_regif`

## Requirements
- R1: Transmit control (offset 0x31C) reads back end-of-frame in bit 0 and the final-word byte count in bits 3:2. Bit 1 and bits 31:4 always read 0. After reset the whole register reads 0.
- R2: A transmit word written while end-of-frame is clear is sent as four bytes: bits 7:0 first, then 15:8, 23:16 and 31:24. tx_last stays low for all four. A byte on offer holds steady while tx_ready is low.
- R3: A word written while end-of-frame is set is sent as count+1 bytes (count 00 gives 1 byte, 11 gives 4 bytes). tx_last is high only on the last of those bytes. End-of-frame reads 0 once that word is accepted, and the count field keeps its value.
- R4: A write to the plain transmit data register (0x320) while bytes are still pending completes without wait states. tx_abort pulses high for exactly one cycle, all pending bytes are dropped, the written word is not sent, and end-of-frame is cleared.
- R5: A write to the stalling transmit data register (0x324) while bytes are pending holds bus_waitreq high until the last pending byte is taken. The word is then accepted without error and sent.
- R6: A control write with bit 1 set drops the pending bytes, pulses tx_abort and clears end-of-frame. The count field takes the written bits 3:2.
- R7: A read of the receive data register (0x318) waits until four bytes have arrived and returns them packed with the first byte in bits 7:0. rx_ready is low while a complete word waits to be read.
- R8: A stalled access that has waited TIMEOUT cycles ends with bus_err high and bus_waitreq low. The word is not taken on transmit, and no bytes are lost on receive.
- R9: Receive status (0x328) reads 0x40 after an rx_crc_err pulse and reads 0 on the next read. All bits other than bit 6 read 0.
- R10: Accesses to unmapped offsets, and reads of the two transmit data registers, return 0 with no wait state and no error. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_read | input | 1 | Read request, held until wait-request is low |
| bus_write | input | 1 | Write request, held until wait-request is low |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the completing cycle |
| bus_waitreq | output | 1 | Stall the current access |
| bus_err | output | 1 | Error response in the completing cycle (timeout) |
| tx_byte | output | 8 | Byte to the framer |
| tx_valid | output | 1 | tx_byte is valid |
| tx_last | output | 1 | This byte ends the frame |
| tx_ready | input | 1 | Framer takes the byte |
| tx_abort | output | 1 | One-cycle frame abort strobe |
| rx_byte | input | 8 | Byte from the framer |
| rx_valid | input | 1 | rx_byte is valid |
| rx_ready | output | 1 | Block can take a byte |
| rx_crc_err | input | 1 | Pulse: a received frame failed its CRC |

## Verification
The properties assume the bus master behaves: read and write are never both high, and address, data and request stay fixed while bus_waitreq is high. They also assume that rx_valid and tx_ready change only between clock edges. The bench drives each access from a single task, holding it until it completes and then dropping it. The framer stream signals are changed only at falling edges, so the held-request assumption is never violated. Concurrent stimulus only adds bytes on the receive side or raises tx_ready, which keeps the bus owned by one transfer at a time.

// File: rtl/hdlc_regif_pkg.sv
// Package: register offsets, select encoding and address decode shared by
// the HDLC frame register interface and its checker.
package hdlc_regif_pkg;

    localparam int unsigned REG_AW  = 12;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned CRC_BIT = 6;

    localparam logic [REG_AW-1:0] OFS_RX_WAIT = 12'h318;
    localparam logic [REG_AW-1:0] OFS_TX_CTRL = 12'h31C;
    localparam logic [REG_AW-1:0] OFS_TX_DATA = 12'h320;
    localparam logic [REG_AW-1:0] OFS_TX_WAIT = 12'h324;
    localparam logic [REG_AW-1:0] OFS_RX_STAT = 12'h328;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_WAIT,
        SEL_TX_CTRL,
        SEL_TX_DATA,
        SEL_TX_WAIT,
        SEL_RX_STAT
    } reg_sel_e;

    // Map a byte address onto a register select
    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        case (a)
            OFS_RX_WAIT: decode_addr = SEL_RX_WAIT;
            OFS_TX_CTRL: decode_addr = SEL_TX_CTRL;
            OFS_TX_DATA: decode_addr = SEL_TX_DATA;
            OFS_TX_WAIT: decode_addr = SEL_TX_WAIT;
            OFS_RX_STAT: decode_addr = SEL_RX_STAT;
            default:     decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/regif_stall_timer.sv
// Counts consecutive cycles in which a bus access is stalled.
// Assumes: stall stays high only while one access is stalled.
// expired goes high once TIMEOUT stall cycles have passed.
module regif_stall_timer #(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic expired
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CW'(TIMEOUT));

    // Advance while stalled and not yet expired, otherwise restart
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (stall && !expired) cnt_q <= cnt_q + CW'(1);
        else                       cnt_q <= '0;
    end
endmodule

// File: rtl/tx_word_unpacker.sv
// Holds one transmit word and hands it to the framer one byte at a time,
// lowest byte first. Assumes load is raised only while idle is high.
// flush drops whatever is still pending and takes priority over load.
module tx_word_unpacker #(
    parameter int unsigned WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [WORD_W-1:0]     load_word,
    input  logic [$clog2(WORD_W/8+1)-1:0] load_cnt,
    input  logic                  load_last,
    input  logic                  flush,
    output logic                  idle,
    output logic [7:0]            tx_byte,
    output logic                  tx_valid,
    output logic                  tx_last,
    input  logic                  tx_ready
);
    localparam int unsigned LANES = WORD_W / 8;
    localparam int unsigned CW    = $clog2(LANES + 1);

    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     left_q;
    logic              last_q;

    assign idle     = (left_q == '0);
    assign tx_valid = !idle;
    assign tx_byte  = word_q[7:0];
    assign tx_last  = last_q && (left_q == CW'(1));

    // Load, shift out on each handshake, or flush the pending bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
            last_q <= 1'b0;
        end else if (flush) begin
            left_q <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            word_q <= load_word;
            left_q <= load_cnt;
            last_q <= load_last;
        end else if (tx_valid && tx_ready) begin
            word_q <= word_q >> 8;
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/rx_word_packer.sv
// Gathers framer bytes into one word, first byte in the lowest lane.
// Assumes take is raised only while full is high. Stops taking bytes
// until the full word has been taken.
module rx_word_packer #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              full,
    output logic [WORD_W-1:0] word,
    input  logic              take
);
    localparam int unsigned LANES = WORD_W / 8;
    localparam int unsigned CW    = $clog2(LANES + 1);
    localparam int unsigned IW    = $clog2(LANES);

    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     lane;

    assign full     = (cnt_q == CW'(LANES));
    assign rx_ready = !full;
    assign word     = word_q;
    assign lane     = cnt_q[IW-1:0];

    // Drop each accepted byte into the next lane, or empty on take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (take) begin
            cnt_q <= '0;
        end else if (rx_valid && rx_ready) begin
            word_q[8*int'(lane) +: 8] <= rx_byte;
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/hdlc_frame_regif.sv
// Register front end between a CPU bus and an HDLC framer's byte streams.
// Decodes the register offsets, holds the control and status bits, and
// raises wait-request for stalling accesses until the data path is ready
// or the stall timer runs out. Assumes the master holds address, data and
// request steady while bus_waitreq is high.
module hdlc_frame_regif
    import hdlc_regif_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_read,
    input  logic              bus_write,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_waitreq,
    output logic              bus_err,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              tx_abort,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_crc_err
);
    localparam int unsigned CW = $clog2(LANES + 1);

    reg_sel_e          sel;
    logic              access, done_ok;
    logic              rx_wait_rd, tx_wait_wr, stall, expired;
    logic              tx_idle, tx_load, plain_abort, discard, abort_now;
    logic              ctrl_wr, stat_rd, rx_take, rx_full;
    logic [WORD_W-1:0] rx_word;
    logic [CW-1:0]     load_cnt;
    logic              eop_q, crc_q, abort_q;
    logic [1:0]        len_q;

    // Decode the access and work out stall, completion and side effects
    always_comb begin
        access      = bus_read || bus_write;
        sel         = access ? decode_addr(bus_addr) : SEL_NONE;
        rx_wait_rd  = bus_read  && (sel == SEL_RX_WAIT);
        tx_wait_wr  = bus_write && (sel == SEL_TX_WAIT);
        stall       = (rx_wait_rd && !rx_full) || (tx_wait_wr && !tx_idle);
        bus_waitreq = stall && !expired;
        bus_err     = stall && expired;
        done_ok     = access && !stall;
        tx_load     = done_ok && bus_write &&
                      ((sel == SEL_TX_WAIT) || ((sel == SEL_TX_DATA) && tx_idle));
        plain_abort = done_ok && bus_write && (sel == SEL_TX_DATA) && !tx_idle;
        ctrl_wr     = done_ok && bus_write && (sel == SEL_TX_CTRL);
        discard     = ctrl_wr && bus_wdata[1];
        abort_now   = plain_abort || discard;
        rx_take     = done_ok && rx_wait_rd;
        stat_rd     = done_ok && bus_read && (sel == SEL_RX_STAT);
        load_cnt    = eop_q ? (CW'(len_q) + CW'(1)) : CW'(LANES);
    end

    // Read data mux for the completing read
    always_comb begin
        bus_rdata = '0;
        if (bus_read) begin
            case (sel)
                SEL_RX_WAIT: bus_rdata = rx_word;
                SEL_TX_CTRL: bus_rdata = {{(WORD_W-4){1'b0}}, len_q, 1'b0, eop_q};
                SEL_RX_STAT: bus_rdata = WORD_W'(crc_q) << CRC_BIT;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // Transmit control: end-of-frame bit and final-word byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_q <= 1'b0;
            len_q <= 2'b00;
        end else begin
            if (ctrl_wr) len_q <= bus_wdata[3:2];
            if (abort_now)              eop_q <= 1'b0;
            else if (ctrl_wr)           eop_q <= bus_wdata[0];
            else if (tx_load && eop_q)  eop_q <= 1'b0;
        end
    end

    // Sticky CRC-error flag (a new event beats the clearing read) and abort strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= abort_now;
            if (rx_crc_err)   crc_q <= 1'b1;
            else if (stat_rd) crc_q <= 1'b0;
        end
    end

    assign tx_abort = abort_q;

    regif_stall_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .expired (expired)
    );

    tx_word_unpacker #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_word (bus_wdata),
        .load_cnt  (load_cnt),
        .load_last (eop_q),
        .flush     (abort_now),
        .idle      (tx_idle),
        .tx_byte   (tx_byte),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    rx_word_packer #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .full     (rx_full),
        .word     (rx_word),
        .take     (rx_take)
    );
endmodule

// File: rtl/hdlc_frame_regif_chk.sv
// Checker for hdlc_frame_regif, attached by bind. Looks only at the ports.
module hdlc_frame_regif_chk
    import hdlc_regif_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_read,
    input logic              bus_write,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              bus_waitreq,
    input logic              bus_err,
    input logic [7:0]        tx_byte,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              tx_ready,
    input logic              tx_abort,
    input logic [7:0]        rx_byte,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_crc_err
);
    int unsigned wait_run;

    // Length of the current run of wait states
    always_ff @(posedge clk) begin
        if (!rst_n)           wait_run <= 0;
        else if (bus_waitreq) wait_run <= wait_run + 1;
        else                  wait_run <= 0;
    end

    assert_last_has_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_byte_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_abort || (tx_valid && $stable(tx_byte))));

    assert_abort_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> !tx_valid);

    assert_wait_needs_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_waitreq |-> (bus_read || bus_write));

    assert_err_ends_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!bus_waitreq && (bus_read || bus_write)));

    assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= TIMEOUT);

    assert_unmapped_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_read || bus_write) && decode_addr(bus_addr) == SEL_NONE)
            |-> (!bus_waitreq && !bus_err && bus_rdata == '0));
endmodule

bind hdlc_frame_regif hdlc_frame_regif_chk #(.TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/test_hdlc_frame_regif.sv
module test_hdlc_frame_regif;
    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_read = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_waitreq, bus_err;
    logic [7:0]  tx_byte;
    logic        tx_valid, tx_last, tx_abort;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        rx_crc_err = 1'b0;

    int checks = 0, fails = 0, aborts = 0;
    bit done = 0;
    logic [7:0] exp_byte[$];
    bit         exp_last[$];

    always #2 clk = ~clk;

    hdlc_frame_regif #(.TIMEOUT(TO)) i_hdlc_frame_regif (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus access held until wait-request drops
    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output bit er, output int waits);
        bit w;
        waits = 0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_write = wr; bus_read = !wr;
        forever begin
            #1;
            w = bus_waitreq; rd = bus_rdata; er = bus_err;
            @(posedge clk);
            if (!w) break;
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        bus_read = 0; bus_write = 0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        bit r;
        @(negedge clk);
        rx_byte = b; rx_valid = 1;
        forever begin
            #1; r = rx_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 0;
    endtask

    function automatic void push_word(input logic [31:0] w, input int n, input bit fin);
        for (int i = 0; i < n; i++) begin
            exp_byte.push_back(w[8*i +: 8]);
            exp_last.push_back(fin && (i == n - 1));
        end
    endfunction

    // Reference model: compare the byte stream against the expected queue every clock
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (tx_abort) aborts++;
            if (tx_valid && tx_ready) begin
                if (exp_byte.size() == 0)
                    chk(0, "R2/R4 unexpected byte", {24'h0, tx_byte}, 32'h0);
                else begin
                    logic [7:0] eb; bit el;
                    eb = exp_byte.pop_front(); el = exp_last.pop_front();
                    chk(tx_byte == eb, "R2 byte order", {24'h0, tx_byte}, {24'h0, eb});
                    chk(tx_last == el, "R3 last flag", {31'h0, tx_last}, {31'h0, el});
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd; bit er; int w; int ab0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        #1;
        chk(tx_valid == 0 && rx_ready == 1 && bus_waitreq == 0, "R1 reset outputs",
            {29'h0, tx_valid, rx_ready, bus_waitreq}, 32'h2);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 0, "R1 control reset", rd, 0);
        xfer(0, 12'h328, 0, rd, er, w); chk(rd == 0, "R9 status reset", rd, 0);

        // R2: plain word, no end-of-frame
        tx_ready = 1;
        xfer(1, 12'h320, 32'h44332211, rd, er, w); push_word(32'h44332211, 4, 0);
        idle(8); chk(exp_byte.size() == 0, "R2 all bytes sent", exp_byte.size(), 0);

        // R1: reserved and command bits read zero
        xfer(1, 12'h31C, 32'hFFFFFFF1, rd, er, w);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 32'h1, "R1 reserved bits zero", rd, 32'h1);

        // R3: final word with three valid bytes
        xfer(1, 12'h31C, 32'h9, rd, er, w);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 32'h9, "R1 control readback", rd, 32'h9);
        xfer(1, 12'h324, 32'hDDCCBBAA, rd, er, w); push_word(32'hDDCCBBAA, 3, 1);
        chk(w == 0 && er == 0, "R3 idle stalling write no wait", w, 0);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 32'h8, "R3 eop auto-clear", rd, 32'h8);
        idle(8); chk(exp_byte.size() == 0, "R3 final bytes sent", exp_byte.size(), 0);

        // R3: one-byte and four-byte final words
        xfer(1, 12'h31C, 32'h1, rd, er, w);
        xfer(1, 12'h320, 32'h000000EE, rd, er, w); push_word(32'hEE, 1, 1);
        xfer(1, 12'h31C, 32'hD, rd, er, w);
        xfer(1, 12'h320, 32'h87654321, rd, er, w); push_word(32'h87654321, 4, 1);
        idle(8); chk(exp_byte.size() == 0, "R3 1- and 4-byte finals", exp_byte.size(), 0);

        // R4: plain write while busy aborts
        tx_ready = 0; ab0 = aborts;
        xfer(1, 12'h320, 32'h11111111, rd, er, w); push_word(32'h11111111, 4, 0);
        xfer(1, 12'h31C, 32'hD, rd, er, w);
        xfer(1, 12'h320, 32'h22222222, rd, er, w);
        exp_byte.delete(); exp_last.delete();
        chk(w == 0 && er == 0, "R4 no wait on abort", w, 0);
        idle(2);
        chk(aborts == ab0 + 1, "R4 single abort pulse", aborts - ab0, 1);
        chk(tx_valid == 0, "R4 pending dropped", tx_valid, 0);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 32'hC, "R4 eop cleared", rd, 32'hC);
        tx_ready = 1; idle(6);

        // R5: stalling write waits for the byte path
        tx_ready = 0; ab0 = aborts;
        xfer(1, 12'h320, 32'h55667788, rd, er, w); push_word(32'h55667788, 4, 0);
        fork
            xfer(1, 12'h324, 32'h0A0B0C0D, rd, er, w);
            begin idle(5); tx_ready = 1; end
        join
        push_word(32'h0A0B0C0D, 4, 0);
        chk(w > 4 && er == 0, "R5 stalled then accepted", w, 5);
        idle(8); chk(exp_byte.size() == 0 && aborts == ab0, "R5 both words sent", exp_byte.size(), 0);

        // R6: discard command
        tx_ready = 0; ab0 = aborts;
        xfer(1, 12'h320, 32'h99999999, rd, er, w); push_word(32'h99999999, 4, 0);
        xfer(1, 12'h31C, 32'h7, rd, er, w);
        exp_byte.delete(); exp_last.delete();
        idle(2);
        chk(aborts == ab0 + 1, "R6 discard abort pulse", aborts - ab0, 1);
        chk(tx_valid == 0, "R6 bytes dropped", tx_valid, 0);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 32'h4, "R6 eop cleared, count kept", rd, 32'h4);
        tx_ready = 1; idle(6);

        // R8: stalling transmit write times out
        tx_ready = 0;
        xfer(1, 12'h320, 32'h0F0E0D0C, rd, er, w); push_word(32'h0F0E0D0C, 4, 0);
        xfer(1, 12'h324, 32'h00000BAD, rd, er, w);
        chk(er == 1 && w == TO, "R8 tx timeout", w, TO);
        tx_ready = 1; idle(8);
        chk(exp_byte.size() == 0, "R8 timed-out word not sent", exp_byte.size(), 0);

        // R7: receive packing
        send_rx(8'h10); send_rx(8'h20); send_rx(8'h30); send_rx(8'h40);
        #1; chk(rx_ready == 0, "R7 full word blocks input", rx_ready, 0);
        xfer(0, 12'h318, 0, rd, er, w);
        chk(rd == 32'h40302010 && w == 0, "R7 packed word", rd, 32'h40302010);
        fork
            xfer(0, 12'h318, 0, rd, er, w);
            begin idle(3); send_rx(8'hA1); send_rx(8'hB2); send_rx(8'hC3); send_rx(8'hD4); end
        join
        chk(rd == 32'hD4C3B2A1 && w > 0 && er == 0, "R7 stalled read", rd, 32'hD4C3B2A1);

        // R8: receive read times out, then bytes still arrive intact
        send_rx(8'h01); send_rx(8'h02);
        xfer(0, 12'h318, 0, rd, er, w);
        chk(er == 1 && w == TO, "R8 rx timeout", w, TO);
        send_rx(8'h03); send_rx(8'h04);
        xfer(0, 12'h318, 0, rd, er, w);
        chk(rd == 32'h04030201 && er == 0, "R8 rx bytes kept", rd, 32'h04030201);

        // R9: CRC-error flag
        @(negedge clk); rx_crc_err = 1; @(negedge clk); rx_crc_err = 0;
        xfer(0, 12'h328, 0, rd, er, w); chk(rd == 32'h40, "R9 crc flag set", rd, 32'h40);
        xfer(0, 12'h328, 0, rd, er, w); chk(rd == 0, "R9 cleared on read", rd, 0);

        // R10: unmapped offsets and write-side data registers
        xfer(0, 12'h100, 0, rd, er, w);
        chk(rd == 0 && w == 0 && er == 0, "R10 unmapped read", rd, 0);
        xfer(1, 12'h200, 32'hFFFFFFFF, rd, er, w);
        xfer(0, 12'h31C, 0, rd, er, w); chk(rd == 32'h4, "R10 unmapped write ignored", rd, 32'h4);
        xfer(0, 12'h320, 0, rd, er, w); chk(rd == 0 && w == 0, "R10 tx data reads zero", rd, 0);
        idle(4);
        chk(tx_valid == 0, "R10 no stray bytes", tx_valid, 0);

        done = 1;
        finish_run();
    end
endmodule